// File: doc/BRIEF.md
# Hashed Page Table Lookup Engine

This engine resolves a translation for one (virtual page number, process ID) pair by searching a hashed page table held in physical memory. A hash of the page number and process ID picks a slot. The slot's byte address is that hash, scaled by the slot size, added to a table base address. The engine then fetches the slot's page table entries one at a time and compares each entry's valid bit, page number and process ID against the request. The first entry that matches ends the search, and its physical page number is returned.

If all entries of the first slot fail to match, the engine derives a second slot index from a different hash and searches that slot in the same way. If both slots are exhausted with no match, it returns a miss. Software then resolves the translation from the complete backup table. The engine takes one request at a time. Its request, response and memory ports each use a valid/ready handshake.

Top module: `hpt_lookup`

## Requirements
- R1: After reset, `req_ready` is 1 and both `resp_valid` and `mem_req_valid` are 0.
- R2: The first memory read of a lookup goes to `tbl_base + H1 * ENTRIES * PTE_BYTES`. Bit k of the SLOT_W-bit index H1 is the XOR of every page-number bit i and every process-ID bit j for which i mod SLOT_W = k and j mod SLOT_W = k.
- R3: Within a slot, read n (counting from 0) goes to the slot address plus n * PTE_BYTES, and the reads are issued strictly in that order. A read address is held stable while `mem_req_ready` is low.
- R4: A memory word is a page table entry laid out as {valid[1], pid[PID_W], vpn[VPN_W], ppn[PPN_W]}, with ppn in the least significant bits. An entry hits only when valid is 1 and both pid and vpn equal the request. An invalid entry, or an entry with a different pid, never hits.
- R5: The search stops at the first hit. A hit at position p of the first slot takes p+1 reads. A hit at position p of the second slot takes ENTRIES+p+1 reads. `resp_ppn` is the ppn of the first hitting entry.
- R6: The second slot is searched only after all ENTRIES entries of the first slot miss. Its index H2 is the bitwise complement of H1, and the slot is addressed like the first.
- R7: When neither slot hits, the response has `resp_hit` = 0 after exactly 2 * ENTRIES reads.
- R8: `req_ready` stays low from the accepted request until the response is taken. `resp_valid`, `resp_hit` and `resp_ppn` are held stable while `resp_ready` is low.
- R9: `tbl_base` is sampled when the request is accepted. Later changes to `tbl_base` do not move the reads of that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | PA_W | Physical base address of the hashed table |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine can accept a request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_pid | input | PID_W | Process ID of the request |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Consumer takes the result |
| resp_hit | output | 1 | 1: translation found, 0: software must resolve |
| resp_ppn | output | PPN_W | Physical page number on a hit |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_ready | output | 1 | Engine takes the read data |
| mem_rsp_data | input | 1+PID_W+VPN_W+PPN_W | Page table entry read |

## Verification
The first read request appears one cycle after the request handshake. Each later read appears one cycle after the previous read's data is taken. The response is raised in the cycle after the data of the hitting entry, or of the last entry, is taken. Because memory stalls vary the total latency, the bench does not wait a fixed number of cycles. It logs every accepted read address, polls `resp_valid` at falling edges, and then compares the whole address log and the read count against a list of addresses worked out in advance from the hash formulas. Stability and the return to idle are sampled at the falling edges that follow, with `resp_ready` held low for two cycles and then pulsed.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_RESP  = 2'd3
    } hpt_state_e;

    function automatic int pte_bits(int vpn_w, int pid_w, int ppn_w);
        return 1 + vpn_w + pid_w + ppn_w;
    endfunction

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
    parameter int VPN_W  = 20,
    parameter int PID_W  = 8,
    parameter int SLOT_W = 6
) (
    input  logic [VPN_W-1:0]  vpn,
    input  logic [PID_W-1:0]  pid,
    input  logic              alt,
    output logic [SLOT_W-1:0] slot
);
    logic [SLOT_W-1:0] fold;

    always_comb begin
        fold = '0;
        for (int i = 0; i < VPN_W; i++) begin
            fold[i % SLOT_W] = fold[i % SLOT_W] ^ vpn[i];
        end
        for (int j = 0; j < PID_W; j++) begin
            fold[j % SLOT_W] = fold[j % SLOT_W] ^ pid[j];
        end
        slot = alt ? ~fold : fold;
    end
endmodule

// File: rtl/hpt_addr.sv
module hpt_addr #(
    parameter int PA_W      = 32,
    parameter int SLOT_W    = 6,
    parameter int IDX_W     = 3,
    parameter int PTE_BYTES = 8
) (
    input  logic [PA_W-1:0]   base,
    input  logic [SLOT_W-1:0] slot,
    input  logic [IDX_W-1:0]  idx,
    output logic [PA_W-1:0]   addr
);
    localparam int PTE_SH = $clog2(PTE_BYTES);

    logic [PA_W-1:0] offset;

    always_comb begin
        offset = '0;
        offset[PTE_SH +: IDX_W] = idx;
        offset[PTE_SH + IDX_W +: SLOT_W] = slot;
        addr = base + offset;
    end
endmodule

// File: rtl/hpt_match.sv
module hpt_match #(
    parameter int VPN_W = 20,
    parameter int PID_W = 8,
    parameter int PPN_W = 16,
    parameter int PTE_W = 1 + VPN_W + PID_W + PPN_W
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [VPN_W-1:0] vpn,
    input  logic [PID_W-1:0] pid,
    output logic             hit,
    output logic [PPN_W-1:0] ppn
);
    logic             e_valid;
    logic [PID_W-1:0] e_pid;
    logic [VPN_W-1:0] e_vpn;

    always_comb begin
        e_valid = pte[PTE_W-1];
        e_pid   = pte[PPN_W + VPN_W +: PID_W];
        e_vpn   = pte[PPN_W +: VPN_W];
        ppn     = pte[PPN_W-1:0];
        hit     = e_valid && (e_pid == pid) && (e_vpn == vpn);
    end
endmodule

// File: rtl/hpt_lookup.sv
module hpt_lookup
    import hpt_pkg::*;
#(
    parameter int VPN_W      = 20,
    parameter int PID_W      = 8,
    parameter int PPN_W      = 16,
    parameter int PA_W       = 32,
    parameter int SLOTS_LOG2 = 6,
    parameter int ENTRIES    = 8,
    parameter int PTE_BYTES  = 8,
    localparam int PTE_W     = pte_bits(VPN_W, PID_W, PPN_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  tbl_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [PID_W-1:0] req_pid,
    output logic             resp_valid,
    input  logic             resp_ready,
    output logic             resp_hit,
    output logic [PPN_W-1:0] resp_ppn,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    output logic             mem_rsp_ready,
    input  logic [PTE_W-1:0] mem_rsp_data
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        hpt_state_e       st;
        logic [VPN_W-1:0] vpn;
        logic [PID_W-1:0] pid;
        logic [PA_W-1:0]  base;
        logic [IDX_W-1:0] idx;
        logic             second;
        logic             hit;
        logic [PPN_W-1:0] ppn;
    } regs_t;

    regs_t q, d;

    logic [SLOTS_LOG2-1:0] slot_idx;
    logic                  ent_hit;
    logic [PPN_W-1:0]      ent_ppn;

    hpt_hash #(.VPN_W(VPN_W), .PID_W(PID_W), .SLOT_W(SLOTS_LOG2)) u_hash (
        .vpn (q.vpn),
        .pid (q.pid),
        .alt (q.second),
        .slot(slot_idx)
    );

    hpt_addr #(.PA_W(PA_W), .SLOT_W(SLOTS_LOG2), .IDX_W(IDX_W), .PTE_BYTES(PTE_BYTES)) u_addr (
        .base(q.base),
        .slot(slot_idx),
        .idx (q.idx),
        .addr(mem_req_addr)
    );

    hpt_match #(.VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W), .PTE_W(PTE_W)) u_match (
        .pte(mem_rsp_data),
        .vpn(q.vpn),
        .pid(q.pid),
        .hit(ent_hit),
        .ppn(ent_ppn)
    );

    always_comb begin
        d = q;
        req_ready     = (q.st == S_IDLE);
        mem_req_valid = (q.st == S_ISSUE);
        mem_rsp_ready = (q.st == S_WAIT);
        resp_valid    = (q.st == S_RESP);
        resp_hit      = q.hit;
        resp_ppn      = q.ppn;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.vpn    = req_vpn;
                    d.pid    = req_pid;
                    d.base   = tbl_base;
                    d.idx    = '0;
                    d.second = 1'b0;
                    d.hit    = 1'b0;
                    d.ppn    = '0;
                    d.st     = S_ISSUE;
                end
            end
            S_ISSUE: begin
                if (mem_req_ready) d.st = S_WAIT;
            end
            S_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ent_hit) begin
                        d.hit = 1'b1;
                        d.ppn = ent_ppn;
                        d.st  = S_RESP;
                    end else if (q.idx != IDX_LAST) begin
                        d.idx = q.idx + 1'b1;
                        d.st  = S_ISSUE;
                    end else if (!q.second) begin
                        d.second = 1'b1;
                        d.idx    = '0;
                        d.st     = S_ISSUE;
                    end else begin
                        d.st = S_RESP;
                    end
                end
            end
            S_RESP: begin
                if (resp_ready) d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/hpt_lookup_chk.sv
module hpt_lookup_chk #(
    parameter int PPN_W   = 16,
    parameter int PA_W    = 32,
    parameter int ENTRIES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_ready,
    input logic             resp_hit,
    input logic [PPN_W-1:0] resp_ppn,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr
);
    localparam int CW = $clog2(2 * ENTRIES) + 2;
    localparam logic [CW-1:0] MAX_READS = CW'(2 * ENTRIES);

    logic [CW-1:0] reads;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reads <= '0;
        end else if (req_valid && req_ready) begin
            reads <= '0;
        end else if (mem_req_valid && mem_req_ready) begin
            reads <= reads + 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> req_ready && !resp_valid && !mem_req_valid);

    p_busy_no_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    p_resp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_ready |=> resp_valid && $stable(resp_hit) && $stable(resp_ppn));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_no_read_at_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |-> !mem_req_valid);

    p_read_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reads <= MAX_READS);

    p_miss_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |-> reads == MAX_READS);
endmodule

bind hpt_lookup hpt_lookup_chk #(.PPN_W(PPN_W), .PA_W(PA_W), .ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/hpt_lookup_test.sv
module hpt_lookup_test;
    localparam int VW = 20, PW = 8, NW = 16, AW = 32, SL = 6, ENT = 8, PB = 8;
    localparam int EW = 1 + VW + PW + NW;

    logic          clk = 0, rst_n = 0;
    logic [AW-1:0] tbl_base = '0;
    logic          req_valid = 0, resp_ready = 0;
    logic [VW-1:0] req_vpn = '0;
    logic [PW-1:0] req_pid = '0;
    logic          req_ready, resp_valid, resp_hit;
    logic [NW-1:0] resp_ppn;
    logic          mem_req_valid, mem_rsp_ready;
    logic          mem_req_ready = 0, mem_rsp_valid = 0;
    logic [AW-1:0] mem_req_addr;
    logic [EW-1:0] mem_rsp_data = '0;

    int n_chk = 0, n_bad = 0;
    logic [EW-1:0] mem [bit [31:0]];
    bit [31:0] rd_log[$];
    bit [31:0] exp_q[$];
    bit        exp_hit;
    bit [NW-1:0] exp_ppn;

    always #5 clk = ~clk;

    hpt_lookup uut (.*);

    function automatic logic [EW-1:0] mem_rd(bit [31:0] a);
        return mem.exists(a) ? mem[a] : '0;
    endfunction

    always @(posedge clk) begin
        mem_req_ready <= ($urandom_range(3) != 0);
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            rd_log.push_back(mem_req_addr);
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem_rd(mem_req_addr);
        end else if (mem_rsp_valid && mem_rsp_ready) begin
            mem_rsp_valid <= 1'b0;
        end
    end

    function automatic bit [SL-1:0] hsh(bit [VW-1:0] v, bit [PW-1:0] p, bit alt);
        bit [SL-1:0] h = '0;
        for (int i = 0; i < VW; i++) h[i % SL] ^= v[i];
        for (int j = 0; j < PW; j++) h[j % SL] ^= p[j];
        return alt ? ~h : h;
    endfunction

    function automatic bit [31:0] ent_addr(bit [31:0] b, bit [SL-1:0] h, int e);
        return b + h * (ENT * PB) + e * PB;
    endfunction

    task automatic put(bit [31:0] b, bit [VW-1:0] v, bit [PW-1:0] p, bit alt, int e,
                       bit vld, bit [PW-1:0] ep, bit [VW-1:0] ev, bit [NW-1:0] en);
        mem[ent_addr(b, hsh(v, p, alt), e)] = {vld, ep, ev, en};
    endtask

    task automatic model(bit [VW-1:0] v, bit [PW-1:0] p, bit [31:0] b);
        exp_q.delete();
        exp_hit = 0;
        exp_ppn = '0;
        for (int s = 0; s < 2; s++) begin
            for (int e = 0; e < ENT; e++) begin
                bit [31:0] a = ent_addr(b, hsh(v, p, s[0]), e);
                logic [EW-1:0] w = mem_rd(a);
                exp_q.push_back(a);
                if (w[EW-1] && w[NW+VW +: PW] == p && w[NW +: VW] == v) begin
                    exp_hit = 1;
                    exp_ppn = w[NW-1:0];
                    return;
                end
            end
        end
    endtask

    task automatic chk(bit ok, string rq, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    task automatic lookup(bit [VW-1:0] v, bit [PW-1:0] p, bit [31:0] b);
        bit busy_ok = 1, first_ok, sec_ok = 1, seq_ok = 1, h0;
        bit [NW-1:0] p0;
        int n = 0;
        model(v, p, b);
        @(negedge clk);
        rd_log.delete();
        req_valid = 1; req_vpn = v; req_pid = p; tbl_base = b;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        tbl_base = $urandom;
        while (!resp_valid && n < 500) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
            n++;
        end
        chk(busy_ok && resp_valid, "R8", "busy until response", resp_valid, 1);
        chk(resp_hit == exp_hit, "R4", "hit flag", resp_hit, exp_hit);
        if (exp_hit) chk(resp_ppn == exp_ppn, "R5", "ppn", resp_ppn, exp_ppn);
        else chk(rd_log.size() == 2 * ENT, "R7", "miss read count", rd_log.size(), 2 * ENT);
        chk(rd_log.size() == exp_q.size(), "R5", "read count", rd_log.size(), exp_q.size());
        first_ok = rd_log.size() > 0 && rd_log[0] == exp_q[0];
        chk(first_ok, "R2", "first address (R9 base)", rd_log.size() > 0 ? rd_log[0] : 0, exp_q[0]);
        for (int k = 1; k < rd_log.size() && k < exp_q.size(); k++) begin
            if (rd_log[k] != exp_q[k]) begin
                if (k == ENT) sec_ok = 0; else seq_ok = 0;
            end
        end
        chk(seq_ok, "R3", "in-slot sequence", seq_ok, 1);
        if (exp_q.size() > ENT) chk(sec_ok, "R6", "second slot address", sec_ok, 1);
        h0 = resp_hit; p0 = resp_ppn;
        @(negedge clk); @(negedge clk);
        chk(resp_valid && resp_hit == h0 && resp_ppn == p0, "R8", "held response", resp_ppn, p0);
        resp_ready = 1;
        @(negedge clk);
        resp_ready = 0;
        chk(!resp_valid && req_ready, "R8", "idle after take", req_ready, 1);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        n_chk++; n_bad++;
        $display("FAIL R8 watchdog: actual %0d expected below %0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit [VW-1:0] v;
        bit [PW-1:0] p;
        bit [31:0]   b;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !resp_valid && !mem_req_valid, "R1", "reset state", req_ready, 1);

        v = 20'h1_2345; p = 8'h3c; b = 32'h0001_0000;
        mem.delete(); put(b, v, p, 0, 0, 1, p, v, 16'h0a01);
        lookup(v, p, b);                                          // R5 first entry
        mem.delete(); put(b, v, p, 0, 7, 1, p, v, 16'h0a07);
        lookup(v, p, b);                                          // R5 last primary
        mem.delete(); put(b, v, p, 1, 7, 1, p, v, 16'h0b07);
        lookup(v, p, b);                                          // R6 last secondary
        mem.delete();
        lookup(v, p, b);                                          // R7 miss
        mem.delete(); put(b, v, p, 0, 2, 0, p, v, 16'h0dead);
        put(b, v, p, 1, 1, 1, p, v, 16'h0b01);
        lookup(v, p, b);                                          // R4 invalid skipped
        mem.delete(); put(b, v, p, 0, 0, 1, p ^ 8'h01, v, 16'h0bad);
        put(b, v, p, 0, 4, 1, p, v, 16'h0a04);
        lookup(v, p, b);                                          // R4 pid mismatch
        mem.delete(); put(b, v, p, 0, 3, 1, p, v, 16'h0a03);
        put(b, v, p, 0, 5, 1, p, v, 16'h0a05);
        lookup(v, p, b);                                          // R5 first match wins

        for (int t = 0; t < 60; t++) begin
            v = $urandom; p = $urandom; b = $urandom & 32'hffff_ffc0;
            mem.delete();
            for (int s = 0; s < 2; s++) begin
                for (int e = 0; e < ENT; e++) begin
                    int r = $urandom_range(9);
                    bit [NW-1:0] n = $urandom;
                    if (r == 4 || r == 5) put(b, v, p, s[0], e, 1, $urandom, $urandom, n);
                    else if (r == 6) put(b, v, p, s[0], e, 1, p, v, n);
                    else if (r == 7) put(b, v, p, s[0], e, 0, p, v, n);
                    else if (r == 8) put(b, v, p, s[0], e, 1, p ^ 8'h80, v, n);
                    else if (r == 9) put(b, v, p, s[0], e, 1, p, v ^ 20'h8_0000, n);
                end
            end
            lookup(v, p, b);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule